// File: doc/BRIEF.md
# Ring-Buffer FIFO on a Two-Port Memory

This block is a single-clock first-in first-out queue. Storage is a two-port memory: one port is only written and the other is only read. A write pointer gives the write port its address and always names the next slot to be filled. A read pointer gives the read port its address and always names the oldest stored word. A small control stage accepts or refuses each request and raises the flags. Both pointers advance by one per accepted operation and return to slot zero after the last slot.

The queue is empty when the two pointers are equal. It is full when one step past the write pointer lands on the read pointer. One slot therefore always stays vacant, and the pointers need no extra wrap bit. The capacity is DEPTH-1 words. DEPTH does not have to be a power of two. Read data is registered, so it appears one cycle after a read is accepted and then holds.

Top module: `ring_fifo`

## Requirements
- R1: After reset is released, `empty` is 1, `full` is 0 and `rd_data` is all zeros.
- R2: `empty` is 1 exactly when the number of stored words is zero.
- R3: `full` is 1 exactly when DEPTH-1 words are stored. With default parameters that is 15 words.
- R4: A write request while `full` is 1 and no read is accepted stores nothing. The queue contents and order are unchanged, which is visible when it is later drained.
- R5: A read request while `empty` is 1 is refused. `empty` stays 1 and `rd_data` keeps its previous value.
- R6: Words leave in the order they were written. An accepted read places the oldest word on `rd_data` after the next rising edge. `rd_data` holds in every cycle with no accepted read.
- R7: Both pointers wrap from slot DEPTH-1 back to slot 0. Order and flags stay correct over many passes around the memory.
- R8: When `wr_en` and `rd_en` are both 1 and the queue is neither empty nor full, both requests are accepted and `full` and `empty` keep their values.
- R9: When `wr_en` and `rd_en` are both 1 and the queue is empty, only the write is accepted and `rd_data` holds. When the queue is full, only the read is accepted and the refused word is lost.
- R10: R1 to R9 also hold when DEPTH is not a power of two (for example DEPTH=5, capacity 4).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both memory ports and both pointers |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH | Word to store |
| rd_en | input | 1 | Read request |
| rd_data | output | WIDTH | Registered output word |
| full | output | 1 | Queue holds DEPTH-1 words |
| empty | output | 1 | Queue holds no words |

## Verification
The assertions assume that `wr_en` and `rd_en` are valid 0/1 levels at every rising edge after reset. They also assume that requests made against a full or empty queue are legal input that the design must refuse, not input the driver avoids. The bench therefore changes every input only on the falling edge. It deliberately drives writes into a full queue, reads from an empty one, and both requests together at both boundaries, so the refusal paths are exercised as well as the normal paths.

// File: rtl/ring_fifo_pkg.sv
package ring_fifo_pkg;

   // Pointer width for a memory of 'depth' slots; never below one bit.
   function automatic int ptr_bits(input int depth);
      int b;
      b = $clog2(depth);
      return (b < 1) ? 1 : b;
   endfunction

   // True when the slot count fills the pointer range exactly.
   function automatic bit is_pow2(input int depth);
      return (depth > 0) && ((depth & (depth - 1)) == 0);
   endfunction

endpackage

// File: rtl/ring_ptr.sv
module ring_ptr
   import ring_fifo_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int PW    = ptr_bits(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   output logic [PW-1:0] ptr,
   output logic [PW-1:0] ptr_next
);

   localparam logic [PW-1:0] LAST_SLOT = PW'(DEPTH - 1);

   // Successor of the current slot, wrapping after the last slot.
   generate
      if (is_pow2(DEPTH)) begin : g_natural_wrap
         assign ptr_next = ptr + 1'b1;
      end else begin : g_compare_wrap
         assign ptr_next = (ptr == LAST_SLOT) ? '0 : ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (step) begin
         ptr <= ptr_next;
      end
   end

   // R7: the pointer returns to slot zero after the last slot
   p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (step && ptr == LAST_SLOT) |=> (ptr == '0));

   // R7: an idle pointer does not move
   p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(ptr));

endmodule

// File: rtl/ring_ctrl.sv
module ring_ctrl
   import ring_fifo_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int PW    = ptr_bits(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          rd_en,
   input  logic [PW-1:0] head,
   input  logic [PW-1:0] head_next,
   input  logic [PW-1:0] tail,
   output logic          wr_go,
   output logic          rd_go,
   output logic          full,
   output logic          empty
);

   always_comb begin
      empty = (head == tail);
      full  = (head_next == tail);
      wr_go = wr_en && !full;
      rd_go = rd_en && !empty;
   end

   // R2 R3: the queue cannot be both empty and full
   p_flags_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(full && empty));

   // R4: a lone write into a full queue leaves it full with head in place
   p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (full && wr_en && !rd_en) |=> (full && $stable(head)));

   // R5: a lone read from an empty queue leaves it empty with tail in place
   p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && rd_en && !wr_en) |=> (empty && $stable(tail)));

   // R8: a paired request in the middle keeps both flags
   p_pair_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && rd_en && !full && !empty) |=> ($stable(full) && $stable(empty)));

   // R9: a paired request on an empty queue leaves it non-empty
   p_pair_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && rd_en && empty) |=> !empty);

endmodule

// File: rtl/ring_mem.sv
module ring_mem
   import ring_fifo_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int WIDTH = 8,
   parameter int PW    = ptr_bits(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [PW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic             re,
   input  logic [PW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);

   logic [WIDTH-1:0] cells [DEPTH];

   // Write port: no reset on the storage array.
   always_ff @(posedge clk) begin
      if (we) begin
         cells[waddr] <= wdata;
      end
   end

   // Read port: registered output, held between reads.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (re) begin
         rdata <= cells[raddr];
      end
   end

   // R6: the output register moves only on a read
   p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !re |=> $stable(rdata));

endmodule

// File: rtl/ring_fifo.sv
module ring_fifo
   import ring_fifo_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             rd_en,
   output logic [WIDTH-1:0] rd_data,
   output logic             full,
   output logic             empty
);

   localparam int PW = ptr_bits(DEPTH);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("ring_fifo: DEPTH must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("ring_fifo: WIDTH must be at least 1");
      end
   endgenerate

   logic [PW-1:0] head, head_next, tail, tail_next;
   logic          wr_go, rd_go;

   ring_ptr #(.DEPTH(DEPTH), .PW(PW)) u_head (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (wr_go),
      .ptr      (head),
      .ptr_next (head_next)
   );

   ring_ptr #(.DEPTH(DEPTH), .PW(PW)) u_tail (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (rd_go),
      .ptr      (tail),
      .ptr_next (tail_next)
   );

   ring_ctrl #(.DEPTH(DEPTH), .PW(PW)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .rd_en     (rd_en),
      .head      (head),
      .head_next (head_next),
      .tail      (tail),
      .wr_go     (wr_go),
      .rd_go     (rd_go),
      .full      (full),
      .empty     (empty)
   );

   ring_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH), .PW(PW)) u_mem (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_go),
      .waddr (head),
      .wdata (wr_data),
      .re    (rd_go),
      .raddr (tail),
      .rdata (rd_data)
   );

   // R6: rd_data changes only after an accepted read
   p_data_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_go |=> $stable(rd_data));

   // R3: a lone accepted read always clears full
   p_read_clears_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_go && !wr_go) |=> !full);

   // R2: a lone accepted write always clears empty
   p_write_clears_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_go && !rd_go) |=> !empty);

   // R6: the read pointer never passes over an unused successor into the head
   p_tail_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_go |=> (tail == $past(tail_next)));

endmodule

// File: tb/ring_fifo_tb.sv
module ring_fifo_tb;

   localparam int DA = 16;
   localparam int DB = 5;
   localparam int W  = 8;
   localparam int CAP_A = DA - 1;
   localparam int CAP_B = DB - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0, rd_en = 1'b0;
   logic [W-1:0] wd_a = '0, wd_b = '0;
   logic [W-1:0] rd_a, rd_b;
   logic full_a, empty_a, full_b, empty_b;

   int checks = 0;
   int errors = 0;
   int wseq_a = 0, rseq_a = 0, wseq_b = 0, rseq_b = 0;
   logic [W-1:0] last_a = '0, last_b = '0;

   always #2.5 clk = ~clk;

   ring_fifo #(.DEPTH(DA), .WIDTH(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wd_a),
      .rd_en(rd_en), .rd_data(rd_a), .full(full_a), .empty(empty_a)
   );

   ring_fifo #(.DEPTH(DB), .WIDTH(W)) u_dut_odd (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wd_b),
      .rd_en(rd_en), .rd_data(rd_b), .full(full_b), .empty(empty_b)
   );

   function automatic logic [W-1:0] word_a(input int n);
      return W'((n * 37 + 11) % 256);
   endfunction

   function automatic logic [W-1:0] word_b(input int n);
      return W'((n * 91 + 200) % 256);
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // One cycle of stimulus on both queues with arithmetic models.
   task automatic step(input bit we, input bit re);
      int ca, cb;
      bit wa, ra, wb, rb;
      string t;
      ca = wseq_a - rseq_a;
      cb = wseq_b - rseq_b;
      wa = we && (ca < CAP_A) && !(re && ca == CAP_A && 0);
      ra = re && (ca > 0);
      wb = we && (cb < CAP_B);
      rb = re && (cb > 0);
      @(negedge clk);
      wr_en = we; rd_en = re;
      wd_a = word_a(wseq_a);
      wd_b = word_b(wseq_b);
      @(posedge clk);
      #1;
      // default queue
      if (ra) begin
         t = (rseq_a >= DA) ? "R7 wrapped order" : "R6 order";
         check(rd_a == word_a(rseq_a), t, rd_a, word_a(rseq_a));
         last_a = word_a(rseq_a);
         rseq_a++;
      end else begin
         t = (re && ca == 0) ? ((we) ? "R9 empty pair hold" : "R5 empty read hold") : "R6 hold";
         check(rd_a == last_a, t, rd_a, last_a);
      end
      if (wa) wseq_a++;
      ca = wseq_a - rseq_a;
      if (we && re && ca > 0 && ca < CAP_A) t = "R8 pair flags";
      else if (we && !re && (ca == CAP_A) && !wa) t = "R4 full write";
      else t = "R2 R3 flags";
      check(empty_a == (ca == 0), t, empty_a, ca == 0);
      check(full_a == (ca == CAP_A), t, full_a, ca == CAP_A);
      // odd-depth queue
      if (rb) begin
         check(rd_b == word_b(rseq_b), "R10 order", rd_b, word_b(rseq_b));
         last_b = word_b(rseq_b);
         rseq_b++;
      end else begin
         check(rd_b == last_b, "R10 hold", rd_b, last_b);
      end
      if (wb) wseq_b++;
      cb = wseq_b - rseq_b;
      check(empty_b == (cb == 0), "R10 empty", empty_b, cb == 0);
      check(full_b == (cb == CAP_B), "R10 full", full_b, cb == CAP_B);
   endtask

   initial begin : watchdog
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: state after reset
      check(empty_a == 1'b1, "R1 empty", empty_a, 1);
      check(full_a == 1'b0, "R1 full", full_a, 0);
      check(rd_a == '0, "R1 rd_data", rd_a, 0);
      check(empty_b == 1'b1 && full_b == 1'b0, "R10 reset flags", {full_b, empty_b}, 1);

      // R5: reads from empty
      for (int i = 0; i < 3; i++) step(1'b0, 1'b1);
      // R3 R4: fill past capacity
      for (int i = 0; i < DA + 4; i++) step(1'b1, 1'b0);
      // R9: paired request while full (default queue)
      step(1'b1, 1'b1);
      // R6 R5: drain past empty
      for (int i = 0; i < DA + 4; i++) step(1'b0, 1'b1);
      // R9: paired request while empty
      step(1'b1, 1'b1);
      // R8: paired requests in the middle
      for (int i = 0; i < 3; i++) step(1'b1, 1'b0);
      for (int i = 0; i < 40; i++) step(1'b1, 1'b1);
      // R7: sweep of all request combinations with changing bias
      for (int i = 0; i < 3000; i++) begin
         int ph;
         ph = (i / 250) % 3;
         case (ph)
            0: step(((i * 7) % 5) < 3, ((i * 3) % 7) < 3);
            1: step(((i * 5) % 7) < 3, ((i * 11) % 5) < 3);
            default: step(i[0], i[1] ^ i[3]);
         endcase
      end
      for (int i = 0; i < DA + 2; i++) step(1'b0, 1'b1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule